// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This unit gathers the event pulses of a raster display engine and turns them into sticky status flags that software can inspect and acknowledge. Five single-cycle sources feed it: frame done for buffer 0, frame done for buffer 1, colour-table load done, pixel FIFO underflow, and loss of sync. Each pulse sets its own flag. The flags stay set until software writes a one to that bit at either status address.

Software sees the flags in two views. The raw view shows every flag that is set. The masked view shows only the flags whose source is enabled. The enable mask has separate set and clear addresses, so one source can be changed without a read-modify-write.

A three-state sequencer drives one level interrupt line:
- In ARMED the line is low. The transition FIRE moves it to ACTIVE when any masked flag is set.
- In ACTIVE the line is high while a masked flag remains. The transition DRAIN moves it to SPENT when the masked view becomes empty.
- From ACTIVE or SPENT, the transition REARM returns it to ARMED on a write of any value to the end-of-interrupt address.
- In SPENT the line stays low even if new flags appear.

A flag that is still pending after REARM therefore produces a new assertion.

Top module: `disp_irq_unit`

## Requirements
- R1: After reset all flags and the enable mask are zero, every address reads zero, and `irq_o` is low.
- R2: A pulse on an event input sets its flag in the raw view whatever the enable mask holds. The flag positions are: bit 9 for frame done of buffer 1, bit 8 for frame done of buffer 0, bit 6 for colour-table load done, bit 5 for FIFO underflow, and bit 2 for sync lost. All other bits read zero.
- R3: The masked view (address 1) reads as the raw view (address 0) ANDed with the enable mask.
- R4: Writing to the enable-set address (address 2) turns on the sources whose bits are 1 in the write data. Bits written as 0 leave the mask unchanged. Reading address 2 or address 3 returns the mask.
- R5: Writing to the enable-clear address (address 3) turns off the sources whose bits are 1 in the write data. Bits written as 0 leave the mask unchanged.
- R6: A write to address 0 or address 1 clears every flag whose bit is 1 in the write data. Writing 0xFFFF clears all flags.
- R7: An event pulse in the same cycle as a write that clears its flag wins, and the flag stays set. Other bits in that write are still cleared.
- R8: In ARMED, `irq_o` rises one cycle after the masked view becomes non-empty, which is two clock edges after the event pulse is sampled. In ACTIVE, `irq_o` is high only while the masked view is non-empty.
- R9: Once the interrupt has fired, `irq_o` does not rise again until a write of any value to the end-of-interrupt address (address 4). After that write, `irq_o` is low for one cycle and then rises again if a masked flag is still pending.
- R10: Read data is registered. It takes the value of the addressed register on the edge that samples `rd_en_i` and holds it until the next read. Address 4 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_frame0_i | input | 1 | Pulse: buffer 0 frame done |
| evt_frame1_i | input | 1 | Pulse: buffer 1 frame done |
| evt_palette_i | input | 1 | Pulse: colour-table load done |
| evt_underflow_i | input | 1 | Pulse: pixel FIFO underflow |
| evt_sync_lost_i | input | 1 | Pulse: sync lost |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is an event pulse and a status write that clears the same flag. The bench drives the pulse and the write on one edge. It then expects the flag to read back as set while another bit named in the same write is cleared.

The second pair is the end-of-interrupt write and a flag that is still pending. The bench issues the write with the flag pending. It expects `irq_o` to be low right after that edge and high one cycle later, and expects the same low-then-high pattern on a second end-of-interrupt write.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

    localparam int unsigned NUM_SRC = 5;

    // Source index -> status bit position. Index order: sync, underflow,
    // colour table, frame 0, frame 1.
    localparam int unsigned SRC_BIT [NUM_SRC] = '{2, 5, 6, 8, 9};

    localparam int unsigned REG_RAW    = 0;
    localparam int unsigned REG_MASKED = 1;
    localparam int unsigned REG_EN_SET = 2;
    localparam int unsigned REG_EN_CLR = 3;
    localparam int unsigned REG_EOI    = 4;

    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_SPENT  = 2'd2
    } irq_state_e;

endpackage

// File: rtl/disp_irq_flags.sv
module disp_irq_flags #(
    parameter int unsigned N = 5
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                flag_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                flag_o[i] <= 1'b1;
            end else if (clr_i[i]) begin
                flag_o[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/disp_irq_enable.sv
module disp_irq_enable #(
    parameter int unsigned N = 5
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] on_i,
    input  logic [N-1:0] off_i,
    output logic [N-1:0] en_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_o <= '0;
        end else begin
            en_o <= (en_o | on_i) & ~off_i;
        end
    end
endmodule

// File: rtl/disp_irq_fsm.sv
module disp_irq_fsm
    import disp_irq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pending_i,
    input  logic eoi_i,
    output logic irq_o
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (pending_i) state_d = ST_ACTIVE;   // FIRE
            end
            ST_ACTIVE: begin
                if (eoi_i)           state_d = ST_ARMED;   // REARM
                else if (!pending_i) state_d = ST_SPENT;   // DRAIN
            end
            ST_SPENT: begin
                if (eoi_i) state_d = ST_ARMED;             // REARM
            end
            default: state_d = ST_ARMED;
        endcase
    end

    always_comb begin
        irq_o = (state_q == ST_ACTIVE) && pending_i;
    end
endmodule

// File: rtl/disp_irq_unit.sv
module disp_irq_unit
    import disp_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              evt_frame0_i,
    input  logic              evt_frame1_i,
    input  logic              evt_palette_i,
    input  logic              evt_underflow_i,
    input  logic              evt_sync_lost_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int unsigned N = NUM_SRC;

    logic [N-1:0] evt_vec, wbits, raw_q, en_q, masked;
    logic [N-1:0] flag_clr, en_on, en_off;
    logic [DATA_W-1:0] raw_bus, masked_bus, en_bus;
    logic sel_raw, sel_masked, sel_set, sel_clr, sel_eoi, eoi;

    assign evt_vec = {evt_frame1_i, evt_frame0_i, evt_palette_i,
                      evt_underflow_i, evt_sync_lost_i};

    assign sel_raw    = (addr_i == ADDR_W'(REG_RAW));
    assign sel_masked = (addr_i == ADDR_W'(REG_MASKED));
    assign sel_set    = (addr_i == ADDR_W'(REG_EN_SET));
    assign sel_clr    = (addr_i == ADDR_W'(REG_EN_CLR));
    assign sel_eoi    = (addr_i == ADDR_W'(REG_EOI));

    for (genvar i = 0; i < N; i++) begin : g_pick
        assign wbits[i] = wdata_i[SRC_BIT[i]];
    end

    always_comb begin
        raw_bus    = '0;
        masked_bus = '0;
        en_bus     = '0;
        for (int i = 0; i < N; i++) begin
            raw_bus[SRC_BIT[i]]    = raw_q[i];
            masked_bus[SRC_BIT[i]] = masked[i];
            en_bus[SRC_BIT[i]]     = en_q[i];
        end
    end

    assign flag_clr = (wr_en_i && (sel_raw || sel_masked)) ? wbits : '0;
    assign en_on    = (wr_en_i && sel_set) ? wbits : '0;
    assign en_off   = (wr_en_i && sel_clr) ? wbits : '0;
    assign eoi      = wr_en_i && sel_eoi;
    assign masked   = raw_q & en_q;

    disp_irq_flags #(.N(N)) u_flags (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (evt_vec),
        .clr_i  (flag_clr),
        .flag_o (raw_q)
    );

    disp_irq_enable #(.N(N)) u_enable (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .on_i   (en_on),
        .off_i  (en_off),
        .en_o   (en_q)
    );

    disp_irq_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pending_i (|masked),
        .eoi_i     (eoi),
        .irq_o     (irq_o)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_o <= '0;
        end else if (rd_en_i) begin
            if (sel_raw)                 rdata_o <= raw_bus;
            else if (sel_masked)         rdata_o <= masked_bus;
            else if (sel_set || sel_clr) rdata_o <= en_bus;
            else                         rdata_o <= '0;
        end
    end
endmodule

// File: rtl/disp_irq_unit_chk.sv
module disp_irq_unit_chk #(
    parameter int unsigned N      = 5,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [N-1:0]      evt_vec,
    input logic [N-1:0]      raw_q,
    input logic [N-1:0]      en_q,
    input logic              eoi,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              irq_o
);
    logic armed_c;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     armed_c <= 1'b1;
        else if (eoi)    armed_c <= 1'b1;
        else if (irq_o)  armed_c <= 1'b0;
    end

    p_event_sticks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_vec != '0) |=> ((raw_q & $past(evt_vec)) == $past(evt_vec)));

    p_irq_needs_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((raw_q & en_q) != '0));

    p_rise_only_armed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> armed_c);

    p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_o));

    p_eoi_reads_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == ADDR_W'(4)) |=> (rdata_o == '0));
endmodule

bind disp_irq_unit disp_irq_unit_chk #(
    .N      (disp_irq_pkg::NUM_SRC),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_vec (evt_vec),
    .raw_q   (raw_q),
    .en_q    (en_q),
    .eoi     (eoi),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
);

// File: tb/test_disp_irq_unit.sv
module test_disp_irq_unit;
    localparam int DW = 32;
    localparam int AW = 3;
    localparam logic [AW-1:0] A_RAW = 0, A_MSK = 1, A_SET = 2, A_CLR = 3, A_EOI = 4;
    // event vector order: [4] frame1, [3] frame0, [2] palette, [1] underflow, [0] sync
    localparam logic [4:0] E_F1 = 5'b10000, E_F0 = 5'b01000, E_PAL = 5'b00100,
                           E_UNF = 5'b00010, E_SYN = 5'b00001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] evt = '0;
    logic wr = 1'b0, rd = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic irq;
    int checks = 0, fails = 0;

    always #4ns clk = ~clk;

    disp_irq_unit #(.DATA_W(DW), .ADDR_W(AW)) i_disp_irq_unit (
        .clk_i(clk), .rst_ni(rst_n),
        .evt_frame0_i(evt[3]), .evt_frame1_i(evt[4]), .evt_palette_i(evt[2]),
        .evt_underflow_i(evt[1]), .evt_sync_lost_i(evt[0]),
        .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; evt = '0; wr = 1'b0; rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input logic [4:0] e);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        apply_reset();
        check("R1 irq after reset", DW'(irq), 0);
        for (int a = 0; a < 5; a++) begin
            do_read(AW'(a), v);
            check("R1 read after reset", v, 0);
        end
    endtask

    task automatic t_event_bits();
        logic [DW-1:0] v;
        logic [4:0] ev [5] = '{E_F1, E_F0, E_PAL, E_UNF, E_SYN};
        int pos [5] = '{9, 8, 6, 5, 2};
        apply_reset();
        for (int i = 0; i < 5; i++) begin
            pulse(ev[i]);
            do_read(A_RAW, v);
            check("R2 raw bit position", v, DW'(1) << pos[i]);
            check("R2 irq stays low with mask off", DW'(irq), 0);
            do_write(A_RAW, 32'hFFFF);
        end
    endtask

    task automatic t_enable();
        logic [DW-1:0] v;
        apply_reset();
        do_write(A_SET, 32'h360);
        do_read(A_SET, v);
        check("R4 set enables", v, 32'h360);
        do_write(A_SET, 32'h004);
        do_read(A_CLR, v);
        check("R4 zeros keep mask", v, 32'h364);
        do_write(A_CLR, 32'h120);
        do_read(A_SET, v);
        check("R5 clear disables", v, 32'h244);
    endtask

    task automatic t_masked();
        logic [DW-1:0] v;
        apply_reset();
        pulse(E_F0 | E_UNF);
        do_write(A_SET, 32'h244);
        do_read(A_MSK, v);
        check("R3 masked empty", v, 0);
        check("R8 no irq when masked empty", DW'(irq), 0);
        do_write(A_SET, 32'h020);
        do_read(A_MSK, v);
        check("R3 masked overlap", v, 32'h020);
        check("R8 irq after enabling pending flag", DW'(irq), 1);
    endtask

    task automatic t_clear();
        logic [DW-1:0] v;
        apply_reset();
        pulse(5'b11111);
        do_write(A_RAW, 32'h100);
        do_read(A_RAW, v);
        check("R6 clear via raw", v, 32'h264);
        do_write(A_MSK, 32'h004);
        do_read(A_RAW, v);
        check("R6 clear via masked", v, 32'h260);
        do_write(A_RAW, 32'hFFFF);
        do_read(A_RAW, v);
        check("R6 clear all", v, 0);
    endtask

    task automatic t_collision();
        logic [DW-1:0] v;
        apply_reset();
        pulse(E_F1 | E_SYN);
        evt = E_F1; wr = 1'b1; addr = A_RAW; wdata = 32'h204;
        @(negedge clk);
        evt = '0; wr = 1'b0;
        do_read(A_RAW, v);
        check("R7 event beats clear", v, 32'h200);
    endtask

    task automatic t_irq();
        apply_reset();
        do_write(A_SET, 32'h100);
        pulse(E_F0);
        check("R8 irq low one cycle after pulse", DW'(irq), 0);
        @(negedge clk);
        check("R8 irq high two edges after pulse", DW'(irq), 1);
        do_write(A_RAW, 32'h100);
        check("R8 irq drops with flag", DW'(irq), 0);
        pulse(E_F0);
        repeat (3) @(negedge clk);
        check("R9 no refire before eoi", DW'(irq), 0);
        do_write(A_EOI, 32'h1234);
        check("R9 low right after eoi", DW'(irq), 0);
        @(negedge clk);
        check("R9 refire after eoi", DW'(irq), 1);
        do_write(A_EOI, 32'h0);
        check("R9 second eoi low", DW'(irq), 0);
        @(negedge clk);
        check("R9 second fresh assertion", DW'(irq), 1);
    endtask

    task automatic t_read();
        logic [DW-1:0] v;
        apply_reset();
        do_read(A_RAW, v);
        pulse(E_PAL);
        @(negedge clk);
        check("R10 rdata holds without read", rdata, 0);
        do_read(A_RAW, v);
        check("R10 read after strobe", v, 32'h040);
        do_read(A_EOI, v);
        check("R10 eoi address reads zero", v, 0);
    endtask

    initial begin
        #(8ns * 100000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_event_bits();
        t_enable();
        t_masked();
        t_clear();
        t_collision();
        t_irq();
        t_read();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule